// File: doc/BRIEF.md
# Priority LED Status Controller

This block drives a green and a red board status LED. Each LED is chosen by a 4-bit source selector, and each has a fixed chain of overrides placed ahead of that selector. The selector can route an Ethernet PHY activity line, a general-purpose pin, the real-time-clock interrupt, a constant level, a cross-chip I/O line or an inverted pin to the LED. The overrides show watchdog activity, a power-on reset that is still held, or a missing user enable.

One free-running prescaler supplies three square waves. The fast and slow waves drive the red LED's default boot-mode blink, which runs fast for flash boot and slow for SD-card boot. The middle-rate wave is the power-blink pattern. Both LED outputs are registered, so a change of selector or source input reaches the pins exactly one clock edge later and never as a combinational glitch.

Top module: `status_led_ctrl`

## Requirements
- R1: While `rst_n` is low, both `led_green` and `led_red` are 0.
- R2: With `wdt_en`=0 and `por_n`=1, `green_sel` codes route these sources to the green LED: 1 `phy_led[0]`, 2 `phy_led[1]`, 3 `phy_led[2]`, 4 `mio7`, 5 `rtc_irq`, 6 constant 0, 7 constant 1, 8 `xio4`, 9 NOT `mio14`, 10 NOR of `mio14` and `mio15`.
- R3: With `wdt_en`=0 and `por_n`=1, `green_sel` codes 0 and 11 to 15 route `mio7` to the green LED.
- R4: With `user_en_dly`=1 and `por_n`=1, `red_sel` codes 1 to 7 route the same sources as in R2, code 8 routes `xio5`, code 9 routes NOT `mio15`, and code 10 routes NOR of `mio14` and `mio15`.
- R5: With `user_en_dly`=1 and `por_n`=1, `red_sel` codes 0 and 11 to 15 route the boot-mode blink to the red LED.
- R6: The boot-mode blink equals bit FAST_SH of a counter that starts at 0 on the first rising edge after reset and rises by one on each edge when `boot_sd`=0, and bit SLOW_SH of that counter when `boot_sd`=1.
- R7: When `wdt_en`=1, the green LED shows `wdt_count[WDT_BIT]`, whatever `por_n` and `green_sel` are.
- R8: When `wdt_en`=0 and `por_n`=0, the green LED is 1, whatever `green_sel` is.
- R9: When `user_en_dly`=0, the red LED shows bit PWR_SH of the same counter, whatever `por_n` and `red_sel` are.
- R10: When `user_en_dly`=1 and `por_n`=0, the red LED is 1, whatever `red_sel` is.
- R11: Both LEDs change only on a rising clock edge and show the value selected by the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| green_sel | input | 4 | Green LED source selector |
| red_sel | input | 4 | Red LED source selector |
| wdt_en | input | 1 | Watchdog is running |
| wdt_count | input | WDT_W | Watchdog counter value |
| por_n | input | 1 | Internal power-on reset, active low |
| user_en_dly | input | 1 | Delayed user enable |
| boot_sd | input | 1 | Boot source: 1 SD card, 0 flash |
| phy_led | input | 3 | Ethernet PHY LED lines 0 to 2 |
| mio7 | input | 1 | General-purpose pin 7 |
| rtc_irq | input | 1 | Real-time-clock interrupt line |
| xio4 | input | 1 | Cross-chip I/O line 4 |
| xio5 | input | 1 | Cross-chip I/O line 5 |
| mio14 | input | 1 | General-purpose pin 14 |
| mio15 | input | 1 | General-purpose pin 15 |
| led_green | output | 1 | Green LED drive |
| led_red | output | 1 | Red LED drive |

## Verification
The assertions check the override chains on every cycle: watchdog over reset for the green LED, power blink over reset for the red one, the forced-on state, the constant selector codes, and the rule that the slow wave never toggles without the fast one. The full selector tables, the fallback for undefined codes, the exact blink periods counted from reset and the one-edge latency are shown only by the bench scenarios. These scenarios sweep every code against several source patterns and follow the blinks across many periods.

// File: rtl/status_led_pkg.sv
package status_led_pkg;

  localparam logic [3:0] SEL_PHY0 = 4'd1;
  localparam logic [3:0] SEL_PHY1 = 4'd2;
  localparam logic [3:0] SEL_PHY2 = 4'd3;
  localparam logic [3:0] SEL_MIO7 = 4'd4;
  localparam logic [3:0] SEL_RTC  = 4'd5;
  localparam logic [3:0] SEL_OFF  = 4'd6;
  localparam logic [3:0] SEL_ON   = 4'd7;
  localparam logic [3:0] SEL_XIO  = 4'd8;
  localparam logic [3:0] SEL_INV  = 4'd9;
  localparam logic [3:0] SEL_NOR  = 4'd10;

  localparam int NUM_LED = 2;
  localparam int LED_GREEN = 0;
  localparam int LED_RED = 1;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic nor_pair(input logic a, input logic b);
    return ~(a | b);
  endfunction

endpackage

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int FAST_SH = 20,
  parameter int SLOW_SH = 23,
  parameter int PWR_SH  = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] taps
);
  import status_led_pkg::*;

  localparam int PRE_W = max3(FAST_SH, SLOW_SH, PWR_SH) + 1;
  localparam int TAP_SH [3] = '{FAST_SH, SLOW_SH, PWR_SH};

  logic [PRE_W-1:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end

  for (genvar i = 0; i < 3; i++) begin : g_tap
    assign taps[i] = pre_cnt[TAP_SH[i]];
  end

endmodule

// File: rtl/led_src_mux.sv
module led_src_mux (
  input  logic [3:0] sel,
  input  logic [2:0] phy,
  input  logic       mio7,
  input  logic       rtc,
  input  logic       alt_xio,
  input  logic       alt_mio,
  input  logic       mio14,
  input  logic       mio15,
  input  logic       dflt,
  output logic       src
);
  import status_led_pkg::*;

  always_comb begin
    case (sel)
      SEL_PHY0: src = phy[0];
      SEL_PHY1: src = phy[1];
      SEL_PHY2: src = phy[2];
      SEL_MIO7: src = mio7;
      SEL_RTC:  src = rtc;
      SEL_OFF:  src = 1'b0;
      SEL_ON:   src = 1'b1;
      SEL_XIO:  src = alt_xio;
      SEL_INV:  src = ~alt_mio;
      SEL_NOR:  src = nor_pair(mio14, mio15);
      default:  src = dflt;
    endcase
  end

endmodule

// File: rtl/status_led_ctrl.sv
module status_led_ctrl #(
  parameter int FAST_SH = 20,
  parameter int SLOW_SH = 23,
  parameter int PWR_SH  = 22,
  parameter int WDT_W   = 8,
  parameter int WDT_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       green_sel,
  input  logic [3:0]       red_sel,
  input  logic             wdt_en,
  input  logic [WDT_W-1:0] wdt_count,
  input  logic             por_n,
  input  logic             user_en_dly,
  input  logic             boot_sd,
  input  logic [2:0]       phy_led,
  input  logic             mio7,
  input  logic             rtc_irq,
  input  logic             xio4,
  input  logic             xio5,
  input  logic             mio14,
  input  logic             mio15,
  output logic             led_green,
  output logic             led_red
);
  import status_led_pkg::*;

  function automatic logic wdt_tap(input logic [WDT_W-1:0] v);
    return v[WDT_BIT];
  endfunction

  logic [2:0] taps;
  logic       blink_fast, blink_slow, blink_pwr, boot_blink;
  logic       green_src, red_src, green_nxt, red_nxt;

  logic [3:0]         sel_v  [NUM_LED];
  logic [NUM_LED-1:0] xio_v, mio_v, dflt_v, src_v;

  led_blink_gen #(
    .FAST_SH(FAST_SH), .SLOW_SH(SLOW_SH), .PWR_SH(PWR_SH)
  ) u_blink (
    .clk(clk), .rst_n(rst_n), .taps(taps)
  );

  assign blink_fast = taps[0];
  assign blink_slow = taps[1];
  assign blink_pwr  = taps[2];
  assign boot_blink = boot_sd ? blink_slow : blink_fast;

  assign sel_v[LED_GREEN]  = green_sel;
  assign sel_v[LED_RED]    = red_sel;
  assign xio_v[LED_GREEN]  = xio4;
  assign xio_v[LED_RED]    = xio5;
  assign mio_v[LED_GREEN]  = mio14;
  assign mio_v[LED_RED]    = mio15;
  assign dflt_v[LED_GREEN] = mio7;
  assign dflt_v[LED_RED]   = boot_blink;

  for (genvar k = 0; k < NUM_LED; k++) begin : g_mux
    led_src_mux u_mux (
      .sel(sel_v[k]), .phy(phy_led), .mio7(mio7), .rtc(rtc_irq),
      .alt_xio(xio_v[k]), .alt_mio(mio_v[k]),
      .mio14(mio14), .mio15(mio15), .dflt(dflt_v[k]), .src(src_v[k])
    );
  end

  assign green_src = src_v[LED_GREEN];
  assign red_src   = src_v[LED_RED];

  always_comb begin
    if (wdt_en)      green_nxt = wdt_tap(wdt_count);
    else if (!por_n) green_nxt = 1'b1;
    else             green_nxt = green_src;
  end

  always_comb begin
    if (!user_en_dly) red_nxt = blink_pwr;
    else if (!por_n)  red_nxt = 1'b1;
    else              red_nxt = red_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_green <= 1'b0;
      led_red   <= 1'b0;
    end else begin
      led_green <= green_nxt;
      led_red   <= red_nxt;
    end
  end

endmodule

// File: rtl/status_led_chk.sv
module status_led_chk #(
  parameter int WDT_W   = 8,
  parameter int WDT_BIT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_en,
  input logic [WDT_W-1:0] wdt_count,
  input logic             por_n,
  input logic             user_en_dly,
  input logic [3:0]       green_sel,
  input logic [3:0]       red_sel,
  input logic             blink_fast,
  input logic             blink_slow,
  input logic             blink_pwr,
  input logic             led_green,
  input logic             led_red
);

  AST_GREEN_WDT: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en |=> led_green == $past(wdt_count[WDT_BIT])); // R7

  AST_GREEN_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_en && !por_n) |=> led_green); // R8

  AST_RED_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    !user_en_dly |=> led_red == $past(blink_pwr)); // R9

  AST_RED_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (user_en_dly && !por_n) |=> led_red); // R10

  AST_GREEN_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_en && por_n && green_sel == 4'd6) |=> !led_green); // R2

  AST_RED_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (user_en_dly && por_n && red_sel == 4'd7) |=> led_red); // R4

  AST_BLINK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blink_slow) |-> !$stable(blink_fast)); // R6

endmodule

bind status_led_ctrl status_led_chk #(.WDT_W(WDT_W), .WDT_BIT(WDT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .wdt_count(wdt_count),
  .por_n(por_n), .user_en_dly(user_en_dly), .green_sel(green_sel),
  .red_sel(red_sel), .blink_fast(blink_fast), .blink_slow(blink_slow),
  .blink_pwr(blink_pwr), .led_green(led_green), .led_red(led_red)
);

// File: tb/status_led_ctrl_tb.sv
module status_led_ctrl_tb;
  localparam int FS = 2;
  localparam int SS = 4;
  localparam int PS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] g_sel = 4'd0, r_sel = 4'd0;
  logic wdt_en = 1'b0;
  logic [7:0] wdt_cnt = 8'd0;
  logic por_n = 1'b1, uen = 1'b1, boot_sd = 1'b0;
  logic [2:0] phy = 3'd0;
  logic mio7 = 1'b0, rtc = 1'b0, x4 = 1'b0, x5 = 1'b0, m14 = 1'b0, m15 = 1'b0;
  logic led_g, led_r;

  always #2 clk = ~clk;

  status_led_ctrl #(.FAST_SH(FS), .SLOW_SH(SS), .PWR_SH(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .green_sel(g_sel), .red_sel(r_sel),
    .wdt_en(wdt_en), .wdt_count(wdt_cnt), .por_n(por_n), .user_en_dly(uen),
    .boot_sd(boot_sd), .phy_led(phy), .mio7(mio7), .rtc_irq(rtc),
    .xio4(x4), .xio5(x5), .mio14(m14), .mio15(m15),
    .led_green(led_g), .led_red(led_r)
  );

  typedef struct {
    logic  g;
    logic  r;
    bit    cg;
    bit    cr;
    string tg;
    string tr;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int unsigned tick = 0;

  function automatic logic wave(input int unsigned t, input int sh);
    return ((t / (1 << sh)) % 2) == 1;
  endfunction

  function automatic logic pick(input logic [3:0] s, input bit red, input logic dflt);
    logic [15:0] tbl;
    tbl = {16{dflt}};
    tbl[1] = phy[0]; tbl[2] = phy[1]; tbl[3] = phy[2];
    tbl[4] = mio7;   tbl[5] = rtc;    tbl[6] = 1'b0; tbl[7] = 1'b1;
    tbl[8] = red ? x5 : x4;
    tbl[9] = red ? !m15 : !m14;
    tbl[10] = !(m14 || m15);
    return tbl[s];
  endfunction

  function automatic logic model_g();
    if (wdt_en) return wdt_cnt[7];
    if (!por_n) return 1'b1;
    return pick(g_sel, 1'b0, mio7);
  endfunction

  function automatic logic model_r();
    if (!uen) return wave(tick, PS);
    if (!por_n) return 1'b1;
    return pick(r_sel, 1'b1, boot_sd ? wave(tick, SS) : wave(tick, FS));
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a falling edge with inputs already set.
  task automatic step(input string tg, input string tr, input bit cg, input bit cr);
    exp_t e;
    e.g = model_g(); e.r = model_r(); e.cg = cg; e.cr = cr; e.tg = tg; e.tr = tr;
    q.push_back(e);
    @(posedge clk);
    tick++;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.cg) check(e.tg, led_g, e.g);
      if (e.cr) check(e.tr, led_r, e.r);
    end
  end

  task automatic set_pattern(input logic [7:0] p);
    phy = p[2:0]; mio7 = p[3]; rtc = p[4]; x4 = p[5]; x5 = p[6];
    m14 = p[7]; m15 = p[0] ^ p[4];
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds both LEDs low even with lighting conditions.
    g_sel = 4'd7; r_sel = 4'd7; por_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 green", led_g, 1'b0);
    check("R1 red", led_r, 1'b0);
    por_n = 1'b1;
    rst_n = 1'b1;

    // R2..R5: every code against several source patterns.
    for (int p = 0; p < 6; p++) begin
      set_pattern(8'(p * 8'h37 + 8'h1B));
      boot_sd = p[0];
      for (int c = 0; c < 16; c++) begin
        g_sel = 4'(c);
        r_sel = 4'(15 - c);
        step((c >= 1 && c <= 10) ? "R2 green mux" : "R3 green default",
             ((15 - c) >= 1 && (15 - c) <= 10) ? "R4 red mux" : "R5 red default",
             1'b1, 1'b1);
      end
    end

    // R6: boot blink rates.
    set_pattern(8'h00);
    r_sel = 4'd0; boot_sd = 1'b0;
    for (int i = 0; i < 24; i++) step("R6", "R6 fast blink", 1'b0, 1'b1);
    boot_sd = 1'b1; r_sel = 4'd13;
    for (int i = 0; i < 70; i++) step("R6", "R6 slow blink", 1'b0, 1'b1);

    // R7: watchdog wins over reset and selector.
    wdt_en = 1'b1; por_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wdt_cnt = 8'(i * 8'h29); g_sel = 4'(i + 5);
      step("R7 watchdog", "R10", 1'b1, 1'b0);
    end

    // R8: reset forces green on; R10: reset forces red on.
    wdt_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      g_sel = (i == 0) ? 4'd6 : 4'(i);
      r_sel = (i == 0) ? 4'd6 : 4'(i + 8);
      step("R8 por green", "R10 por red", 1'b1, 1'b1);
    end

    // R9: power blink wins over reset and selector.
    uen = 1'b0; r_sel = 4'd7;
    for (int i = 0; i < 30; i++) step("R8", "R9 power blink", 1'b1, 1'b1);

    // R11: mid-cycle input change does not reach the LED before the edge.
    uen = 1'b1; por_n = 1'b1; g_sel = 4'd6; r_sel = 4'd6;
    step("R11 setup", "R11 setup", 1'b1, 1'b1);
    g_sel = 4'd7; r_sel = 4'd7;
    #1;
    check("R11 green held", led_g, 1'b0);
    check("R11 red held", led_r, 1'b0);
    @(negedge clk);
    step("R11 green edge", "R11 red edge", 1'b1, 1'b1);
    step("R11 green edge", "R11 red edge", 1'b1, 1'b1);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule